// File: doc/BRIEF.md
# Inter-Core Token Channel with Paired Semaphores

This block carries fixed-width data tokens from a producing core to a consuming core through a small circular store of `SLOTS` entries. Two counting semaphores pace the store. One counts free slots and starts at `SLOTS`. The other counts filled slots and starts at zero. Because each side must take a count from its own semaphore before it may touch a slot, and gives a count to the other semaphore when it lets go, the two sides take turns on every slot. The store never loses or overwrites a token.

Each side follows the same three steps: claim a slot, move one token, release the slot. A claim returns a one-cycle grant or deny pulse. The token moves over a valid/ready stream. The sender offers `snd_valid` and the block answers with `snd_ready`. The block offers `rcv_valid` and the receiver answers with `rcv_ready`. Each side also has a notification interrupt, given both as a one-cycle pulse and as a sticky flag that is cleared by writing one.

The `demand_mode` input selects one of two handshakes. In push operation the sender is told when space opens. In pull operation a receiver that finds the store empty sends a request interrupt to the sender. With `SLOTS` = 2 the store acts as a ping-pong pair: one slot can be filled while the other is drained.

Top module: `tc_token_channel`

## Requirements
- R1: After reset, `free_cnt` equals SLOTS and `full_cnt` is 0. Both interrupt flags are 0, and `snd_ready` and `rcv_valid` are low.
- R2: A sender claim is granted if the sender holds no slot and `free_cnt` > 0. A granted claim gives a `snd_grant` pulse on the next cycle and lowers `free_cnt` by one. Any other claim gives a `snd_deny` pulse on the next cycle and changes no count or index.
- R3: A receiver claim is granted if the receiver holds no slot and `full_cnt` > 0. A granted claim gives a `rcv_grant` pulse on the next cycle and lowers `full_cnt` by one. Any other claim gives a `rcv_deny` pulse on the next cycle and changes no count or index.
- R4: `snd_ready` is high only while the sender holds a claimed slot that has not yet been written. A cycle with `snd_valid` and `snd_ready` both high stores exactly one token. `snd_valid` at any other time is ignored.
- R5: `rcv_valid` is high only while the receiver holds a claimed slot that has not yet been read. `rcv_data` is then the oldest released token not yet read, so tokens leave in the order they were written and the indexes wrap modulo SLOTS.
- R6: A release takes effect only after that side has moved its token. A sender release raises `full_cnt` by one. A receiver release raises `free_cnt` by one. A release at any other time is ignored.
- R7: Claims and releases from both sides in the same cycle are all applied. `free_cnt` + `full_cnt` + (slots held by either side) always equals SLOTS.
- R8: In both modes, an effective sender release pulses `rcv_irq` on the next cycle.
- R9: In push operation (`demand_mode` = 0), an effective receiver release pulses `snd_irq` on the next cycle.
- R10: In pull operation (`demand_mode` = 1), a receiver claim made while it holds no slot and `full_cnt` is 0 records a request. The first such claim pulses `snd_irq` on the next cycle. Further such claims are suppressed until a sender release clears the request.
- R11: Each interrupt pulse also sets its sticky flag. Writing 1 to the matching clear input clears the flag. If a pulse and a clear fall in the same cycle, the pulse wins.
- R12: With SLOTS = 2, the sender can claim and fill the second slot while the receiver still holds the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| demand_mode | input | 1 | 0 selects push notification, 1 selects pull requests |
| snd_claim | input | 1 | Sender requests a free slot |
| snd_grant | output | 1 | Sender claim granted (pulse) |
| snd_deny | output | 1 | Sender claim refused (pulse) |
| snd_valid | input | 1 | Sender offers a token |
| snd_ready | output | 1 | Block accepts a token this cycle |
| snd_data | input | TOKEN_W | Token from the sender |
| snd_release | input | 1 | Sender hands its filled slot over |
| snd_irq | output | 1 | Interrupt pulse toward the sender |
| snd_irq_flag | output | 1 | Sticky copy of snd_irq |
| snd_irq_clr | input | 1 | Write-one-to-clear for snd_irq_flag |
| rcv_claim | input | 1 | Receiver requests a filled slot |
| rcv_grant | output | 1 | Receiver claim granted (pulse) |
| rcv_deny | output | 1 | Receiver claim refused (pulse) |
| rcv_valid | output | 1 | Block offers a token |
| rcv_ready | input | 1 | Receiver takes the token this cycle |
| rcv_data | output | TOKEN_W | Token toward the receiver |
| rcv_release | input | 1 | Receiver hands its emptied slot back |
| rcv_irq | output | 1 | Interrupt pulse toward the receiver |
| rcv_irq_flag | output | 1 | Sticky copy of rcv_irq |
| rcv_irq_clr | input | 1 | Write-one-to-clear for rcv_irq_flag |
| free_cnt | output | CNT_W | Free-slot semaphore value |
| full_cnt | output | CNT_W | Filled-slot semaphore value |

## Verification
The claim responses, both semaphore counts, both interrupt pulses and both sticky flags are registered. Each is due one cycle after the clock edge that samples the stimulus. The bench drives inputs on the falling edge. It samples these outputs just after the next rising edge and compares them with a model that it steps at that same edge. `snd_ready`, `rcv_valid` and `rcv_data` depend only on state already registered, so the bench checks them in the same cycle, before the edge that acts on them.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    SIDE_IDLE = 2'd0,
    SIDE_HELD = 2'd1,
    SIDE_DONE = 2'd2
  } side_st_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/tc_sema.sv
module tc_sema #(
  parameter int CNT_W = 2,
  parameter int INIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             give,
  output logic [CNT_W-1:0] count,
  output logic             avail
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= CNT_W'(INIT);
    else        cnt_q <= cnt_q - CNT_W'(take) + CNT_W'(give);
  end

  assign count = cnt_q;
  assign avail = (cnt_q != '0);
endmodule

// File: rtl/tc_side.sv
module tc_side
  import tc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic claim,
  input  logic avail,
  input  logic xfer_req,
  input  logic release_i,
  output logic take,
  output logic give,
  output logic xfer,
  output logic open_o,
  output logic held,
  output logic grant,
  output logic deny
);
  side_st_e st_q, st_d;
  logic     grant_q, deny_q;

  assign take   = claim && (st_q == SIDE_IDLE) && avail;
  assign give   = release_i && (st_q == SIDE_DONE);
  assign open_o = (st_q == SIDE_HELD);
  assign xfer   = xfer_req && open_o;
  assign held   = (st_q != SIDE_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SIDE_IDLE: if (take) st_d = SIDE_HELD;
      SIDE_HELD: if (xfer) st_d = SIDE_DONE;
      SIDE_DONE: if (give) st_d = SIDE_IDLE;
      default:   st_d = SIDE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SIDE_IDLE;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      grant_q <= take;
      deny_q  <= claim && !take;
    end
  end

  assign grant = grant_q;
  assign deny  = deny_q;
endmodule

// File: rtl/tc_ring.sv
module tc_ring
  import tc_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         wr_adv,
  input  logic         rd_adv,
  output logic [W-1:0] rd_data
);
  localparam int IDX_W = idx_bits(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] wr_idx, rd_idx;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
    end else begin
      if (wr_adv) wr_idx <= step_idx(wr_idx);
      if (rd_adv) rd_idx <= step_idx(rd_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/tc_notify.sv
module tc_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  output logic pulse,
  output logic flag
);
  logic pulse_q, flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (fire)     flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign pulse = pulse_q;
  assign flag  = flag_q;
endmodule

// File: rtl/tc_token_channel.sv
module tc_token_channel
  import tc_pkg::*;
#(
  parameter int TOKEN_W = 16,
  parameter int SLOTS   = 2,
  parameter int CNT_W   = cnt_bits(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               demand_mode,
  input  logic               snd_claim,
  output logic               snd_grant,
  output logic               snd_deny,
  input  logic               snd_valid,
  output logic               snd_ready,
  input  logic [TOKEN_W-1:0] snd_data,
  input  logic               snd_release,
  output logic               snd_irq,
  output logic               snd_irq_flag,
  input  logic               snd_irq_clr,
  input  logic               rcv_claim,
  output logic               rcv_grant,
  output logic               rcv_deny,
  output logic               rcv_valid,
  input  logic               rcv_ready,
  output logic [TOKEN_W-1:0] rcv_data,
  input  logic               rcv_release,
  output logic               rcv_irq,
  output logic               rcv_irq_flag,
  input  logic               rcv_irq_clr,
  output logic [CNT_W-1:0]   free_cnt,
  output logic [CNT_W-1:0]   full_cnt
);
  logic s_take, s_give, s_xfer, s_open, s_held;
  logic r_take, r_give, r_xfer, r_open, r_held;
  logic free_av, full_av;
  logic req_pend, req_cond, snd_fire;

  // free-slot semaphore: sender takes, receiver gives back
  tc_sema #(.CNT_W(CNT_W), .INIT(SLOTS)) u_free (
    .clk(clk), .rst_n(rst_n), .take(s_take), .give(r_give),
    .count(free_cnt), .avail(free_av));

  // filled-slot semaphore: receiver takes, sender gives
  tc_sema #(.CNT_W(CNT_W), .INIT(0)) u_full (
    .clk(clk), .rst_n(rst_n), .take(r_take), .give(s_give),
    .count(full_cnt), .avail(full_av));

  tc_side u_snd (
    .clk(clk), .rst_n(rst_n), .claim(snd_claim), .avail(free_av),
    .xfer_req(snd_valid), .release_i(snd_release),
    .take(s_take), .give(s_give), .xfer(s_xfer), .open_o(s_open),
    .held(s_held), .grant(snd_grant), .deny(snd_deny));

  tc_side u_rcv (
    .clk(clk), .rst_n(rst_n), .claim(rcv_claim), .avail(full_av),
    .xfer_req(rcv_ready), .release_i(rcv_release),
    .take(r_take), .give(r_give), .xfer(r_xfer), .open_o(r_open),
    .held(r_held), .grant(rcv_grant), .deny(rcv_deny));

  tc_ring #(.W(TOKEN_W), .DEPTH(SLOTS)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(s_xfer), .wr_data(snd_data),
    .wr_adv(s_give), .rd_adv(r_give), .rd_data(rcv_data));

  assign snd_ready = s_open;
  assign rcv_valid = r_open;

  // pull request: idle receiver finds nothing to read
  assign req_cond = demand_mode && rcv_claim && !r_held && !full_av;
  assign snd_fire = demand_mode ? (req_cond && !req_pend) : r_give;

  always_ff @(posedge clk) begin
    if (!rst_n)        req_pend <= 1'b0;
    else if (s_give)   req_pend <= 1'b0;
    else if (req_cond) req_pend <= 1'b1;
  end

  tc_notify u_snd_irq (
    .clk(clk), .rst_n(rst_n), .fire(snd_fire), .clr(snd_irq_clr),
    .pulse(snd_irq), .flag(snd_irq_flag));

  tc_notify u_rcv_irq (
    .clk(clk), .rst_n(rst_n), .fire(s_give), .clr(rcv_irq_clr),
    .pulse(rcv_irq), .flag(rcv_irq_flag));
endmodule

// File: rtl/tc_token_channel_chk.sv
module tc_token_channel_chk #(
  parameter int SLOTS = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             demand_mode,
  input logic             snd_claim,
  input logic             snd_grant,
  input logic             snd_deny,
  input logic             rcv_claim,
  input logic             rcv_grant,
  input logic             rcv_deny,
  input logic             snd_irq,
  input logic             snd_irq_flag,
  input logic             rcv_irq,
  input logic             rcv_irq_flag,
  input logic             s_held,
  input logic             r_held,
  input logic             req_pend,
  input logic [CNT_W-1:0] free_cnt,
  input logic [CNT_W-1:0] full_cnt
);
  assert_snd_empty_deny_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_claim && free_cnt == '0) |=> (snd_deny && !snd_grant));

  assert_rcv_empty_deny_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_claim && full_cnt == '0) |=> (rcv_deny && !rcv_grant));

  assert_slot_conservation_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(free_cnt) + int'(full_cnt) + int'(s_held) + int'(r_held)) == SLOTS);

  assert_rcv_irq_has_token_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_irq |-> (full_cnt != '0));

  assert_pull_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (demand_mode && rcv_claim && !r_held && full_cnt == '0 && !req_pend) |=> snd_irq);

  assert_snd_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snd_irq |-> snd_irq_flag);

  assert_rcv_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_irq |-> rcv_irq_flag);
endmodule

bind tc_token_channel tc_token_channel_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .demand_mode(demand_mode),
  .snd_claim(snd_claim), .snd_grant(snd_grant), .snd_deny(snd_deny),
  .rcv_claim(rcv_claim), .rcv_grant(rcv_grant), .rcv_deny(rcv_deny),
  .snd_irq(snd_irq), .snd_irq_flag(snd_irq_flag),
  .rcv_irq(rcv_irq), .rcv_irq_flag(rcv_irq_flag),
  .s_held(s_held), .r_held(r_held), .req_pend(req_pend),
  .free_cnt(free_cnt), .full_cnt(full_cnt));

// File: tb/sim_tc_token_channel.sv
module sim_tc_token_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 16;
  localparam int SLOTS = 2;
  localparam int CW    = $clog2(SLOTS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic demand_mode = 1'b0;
  logic snd_claim = 0, snd_valid = 0, snd_release = 0, snd_irq_clr = 0;
  logic rcv_claim = 0, rcv_ready = 0, rcv_release = 0, rcv_irq_clr = 0;
  logic [W-1:0] snd_data = '0;
  logic snd_grant, snd_deny, snd_ready, snd_irq, snd_irq_flag;
  logic rcv_grant, rcv_deny, rcv_valid, rcv_irq, rcv_irq_flag;
  logic [W-1:0] rcv_data;
  logic [CW-1:0] free_cnt, full_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_token_channel #(.TOKEN_W(W), .SLOTS(SLOTS)) u0 (
    .clk(clk), .rst_n(rst_n), .demand_mode(demand_mode),
    .snd_claim(snd_claim), .snd_grant(snd_grant), .snd_deny(snd_deny),
    .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_data(snd_data),
    .snd_release(snd_release), .snd_irq(snd_irq), .snd_irq_flag(snd_irq_flag),
    .snd_irq_clr(snd_irq_clr),
    .rcv_claim(rcv_claim), .rcv_grant(rcv_grant), .rcv_deny(rcv_deny),
    .rcv_valid(rcv_valid), .rcv_ready(rcv_ready), .rcv_data(rcv_data),
    .rcv_release(rcv_release), .rcv_irq(rcv_irq), .rcv_irq_flag(rcv_irq_flag),
    .rcv_irq_clr(rcv_irq_clr), .free_cnt(free_cnt), .full_cnt(full_cnt));

  int n_chk = 0, n_fail = 0;

  // reference model state
  int m_free = SLOTS, m_full = 0;
  bit m_sh = 0, m_sd = 0, m_rh = 0, m_rd = 0, m_pend = 0;
  bit m_sflag = 0, m_rflag = 0;
  bit e_sg = 0, e_sdn = 0, e_rg = 0, e_rdn = 0, e_sirq = 0, e_rirq = 0;
  logic [W-1:0] m_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit w_open(input bit h, input bit d);
    return h && !d;
  endfunction

  task automatic step(input bit sc, input bit sv, input logic [W-1:0] sd, input bit sr,
                      input bit rc, input bit rr, input bit rl,
                      input bit sclr, input bit rclr);
    bit gs, gr, wr, rd, rels, relr, req, sfire;
    @(negedge clk);
    snd_claim = sc; snd_valid = sv; snd_data = sd; snd_release = sr;
    rcv_claim = rc; rcv_ready = rr; rcv_release = rl;
    snd_irq_clr = sclr; rcv_irq_clr = rclr;
    #1;
    chk("R4 snd_ready", 32'(snd_ready), 32'(w_open(m_sh, m_sd)));
    chk("R5 rcv_valid", 32'(rcv_valid), 32'(w_open(m_rh, m_rd)));
    if (w_open(m_rh, m_rd) && m_q.size() > 0)
      chk("R5 rcv_data order", 32'(rcv_data), 32'(m_q[0]));
    @(posedge clk);
    gs   = sc && !m_sh && m_free > 0;
    gr   = rc && !m_rh && m_full > 0;
    wr   = sv && w_open(m_sh, m_sd);
    rd   = rr && w_open(m_rh, m_rd);
    rels = sr && m_sh && m_sd;
    relr = rl && m_rh && m_rd;
    req  = demand_mode && rc && !m_rh && m_full == 0;
    sfire = demand_mode ? (req && !m_pend) : relr;
    if (wr) m_q.push_back(sd);
    if (rd) void'(m_q.pop_front());
    m_free = m_free - int'(gs) + int'(relr);
    m_full = m_full - int'(gr) + int'(rels);
    if (gs) begin m_sh = 1; m_sd = 0; end
    else if (wr) m_sd = 1;
    else if (rels) begin m_sh = 0; m_sd = 0; end
    if (gr) begin m_rh = 1; m_rd = 0; end
    else if (rd) m_rd = 1;
    else if (relr) begin m_rh = 0; m_rd = 0; end
    if (rels) m_pend = 0; else if (req) m_pend = 1;
    e_sg = gs; e_sdn = sc && !gs; e_rg = gr; e_rdn = rc && !gr;
    e_sirq = sfire; e_rirq = rels;
    if (sfire) m_sflag = 1; else if (sclr) m_sflag = 0;
    if (rels)  m_rflag = 1; else if (rclr) m_rflag = 0;
    #1;
    chk("R2 snd_grant", 32'(snd_grant), 32'(e_sg));
    chk("R2 snd_deny",  32'(snd_deny),  32'(e_sdn));
    chk("R3 rcv_grant", 32'(rcv_grant), 32'(e_rg));
    chk("R3 rcv_deny",  32'(rcv_deny),  32'(e_rdn));
    chk("R6 R7 free_cnt", 32'(free_cnt), 32'(m_free));
    chk("R6 R7 full_cnt", 32'(full_cnt), 32'(m_full));
    chk("R8 rcv_irq", 32'(rcv_irq), 32'(e_rirq));
    chk("R9 R10 snd_irq", 32'(snd_irq), 32'(e_sirq));
    chk("R11 snd_irq_flag", 32'(snd_irq_flag), 32'(m_sflag));
    chk("R11 rcv_irq_flag", 32'(rcv_irq_flag), 32'(m_rflag));
  endtask

  task automatic idle();
    step(0, 0, '0, 0, 0, 0, 0, 0, 0);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 free_cnt", 32'(free_cnt), SLOTS);
    chk("R1 full_cnt", 32'(full_cnt), 0);
    chk("R1 flags", 32'({snd_irq_flag, rcv_irq_flag}), 0);
    chk("R1 ready/valid", 32'({snd_ready, rcv_valid}), 0);

    // R6: early releases ignored
    step(0, 0, '0, 1, 0, 0, 1, 0, 0);
    // R12 ping-pong, push mode (R9)
    step(1, 0, '0, 0, 0, 0, 0, 0, 0);
    step(0, 0, '0, 1, 0, 0, 0, 0, 0);            // R6 release before write ignored
    step(0, 1, 16'hA001, 0, 0, 0, 0, 0, 0);
    step(0, 0, '0, 1, 0, 0, 0, 0, 0);
    step(1, 0, '0, 0, 1, 0, 0, 0, 0);            // both claim together
    chk("R12 sender got second slot", 32'(snd_grant), 1);
    chk("R12 receiver holds first", 32'(rcv_grant), 1);
    step(0, 1, 16'hB002, 0, 0, 1, 0, 0, 0);      // fill and drain together
    step(1, 0, '0, 1, 0, 0, 1, 0, 0);            // both release, sender claim same cycle denied
    chk("R9 push snd_irq on receiver release", 32'(snd_irq), 1);
    step(1, 0, '0, 0, 1, 0, 0, 1, 1);            // R11 clear on flags
    step(0, 0, '0, 0, 0, 1, 1, 0, 0);
    step(0, 0, '0, 0, 0, 0, 1, 0, 0);

    // R10 pull mode request and suppression
    demand_mode = 1'b1;
    step(0, 0, '0, 0, 0, 0, 0, 1, 1);
    step(0, 0, '0, 1, 0, 0, 0, 0, 0);
    // drain until empty
    repeat (6) step(0, 0, '0, 0, 1, 1, 1, 0, 0);
    step(0, 0, '0, 0, 1, 0, 0, 0, 0);
    step(0, 0, '0, 0, 1, 0, 0, 0, 0);
    chk("R10 repeat request suppressed", 32'(snd_irq), 0);
    step(1, 0, '0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 16'hC003, 0, 0, 0, 0, 0, 0);
    step(0, 0, '0, 1, 0, 0, 0, 0, 0);
    chk("R8 pull notify", 32'(rcv_irq), 1);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 700 == 0) demand_mode = $urandom_range(0, 1) != 0;
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) != 0, W'($urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 1) != 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
    end
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule